// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block drives the command bus of an SDR SDRAM from reset until the memory is ready for use. After reset it keeps the bus idle for the power-up pause of 100 µs. It then precharges every bank and issues eight auto-refresh commands. Last, it loads the mode register with the CAS latency, burst length and wrap order chosen by parameters. A done flag tells the access controller when it may start issuing commands.

After initialization the block keeps count of owed refreshes. One refresh falls due every 15.6 µs, which gives 4096 refreshes in 64 ms. While refreshes are owed the block asks the access controller for the bus. When the bus is granted, it precharges all banks and then issues every owed refresh back to back, with one row cycle time between refreshes. Up to eight postponed refreshes are kept.

A level request input puts the memory into self-refresh, using the same grant handshake. When the request is dropped, the block raises clock enable again and keeps the bus to itself until the self-refresh exit time has passed.

Top module: `sdram_boot_refresh`

## Requirements
- R1: While reset is high, the outputs are: command NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), address zero, clock enable high, and `init_done`, `ref_req` and `ref_busy` all low.
- R2: After reset is released, the block drives NOP for INIT_WAIT = 100·CLK_PER_US cycles. It then issues PRECHARGE ALL (4'b0010 with address bit 10 high). TRP cycles later it issues the first of exactly eight AUTO REFRESH commands (4'b0001), spaced TRC cycles apart. TRP is 30 ns and TRC is 75 ns, each rounded up to whole clocks.
- R3: MODE REGISTER SET (4'b0000) follows the eighth refresh by TRC cycles. Its address carries the burst code in bits [2:0] (1→0, 2→1, 4→2, 8→3, full page→7), the wrap order in bit 3 (1 = interleaved) and the CAS latency in bits [6:4]. All other address bits are zero.
- R4: `init_done` rises exactly two cycles after MODE REGISTER SET and stays high until reset.
- R5: Once `init_done` is high, one refresh becomes owed every REF_INTERVAL = 15.6·CLK_PER_US cycles. `ref_req` is high while the block is idle and a refresh is owed or self-refresh is requested.
- R6: A grant seen while `ref_req` is high starts a burst, and `ref_busy` rises in the same cycle. The burst is PRECHARGE ALL, then one AUTO REFRESH per owed refresh, the first TRP after the precharge and the rest TRC apart. A refresh that falls due during the burst is added to it. `ref_busy` falls TRC after the last refresh.
- R7: The count of owed refreshes saturates at MAX_PEND = 8. A grant that arrives after a long delay therefore yields exactly eight refreshes.
- R8: Self-refresh is requested by holding `self_ref_req` high; the request is registered, so the block sees it one cycle later. On grant the block issues PRECHARGE ALL, and TRP later an AUTO REFRESH encoding with clock enable low. Owed refreshes are then discarded and `ref_busy` stays high.
- R9: After the request drops, clock enable rises and only NOP is driven for TRC+2 cycles. `ref_busy` then falls.
- R10: A grant has no effect while `ref_req` is low: the command stays NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| self_ref_req | input | 1 | Level request for self-refresh |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins (bit 10 = all banks, mode word) |
| sd_cke | output | 1 | Clock enable |
| init_done | output | 1 | Initialization complete |
| ref_req | output | 1 | Bus request for refresh or self-refresh |
| ref_busy | output | 1 | Block owns the command bus |

## Verification
Two functions can act on the owed-refresh count in the same clock edge: the interval tick adds one owed refresh, and a burst refresh removes one. The count must then stay unchanged, and the burst must grow by one refresh. The bench provokes this case by timing its grant against the interval counter of its own reference model, so that the third refresh of a burst lands on the tick edge. It then judges the case twice: by comparing every cycle against the model, and by checking that the burst length equals the owed count at grant plus one.

// File: rtl/sdram_boot_refresh_pkg.sv
package sdram_boot_refresh_pkg;

  // Encoding order: {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_t;

  // Mode register contents: [6:4] CAS latency, [3] wrap order, [2:0] burst code
  function automatic logic [6:0] mode_bits(int cas_lat, int burst_len, bit interleave);
    logic [2:0] bcode;
    case (burst_len)
      1:       bcode = 3'd0;
      2:       bcode = 3'd1;
      4:       bcode = 3'd2;
      8:       bcode = 3'd3;
      default: bcode = 3'd7;  // full page
    endcase
    return {3'(cas_lat), interleave, bcode};
  endfunction

endpackage

// File: rtl/sdram_ref_tick.sv
module sdram_ref_tick #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [W-1:0] cnt;

  assign tick = en && (cnt == W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdram_ref_backlog.sv
module sdram_ref_backlog #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic owed
);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] cnt;

  assign owed = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (cnt != PW'(MAX_PEND)) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
  import sdram_boot_refresh_pkg::*;
#(
  parameter int CLK_PER_US      = 100,
  parameter int CAS_LAT         = 3,
  parameter int BURST_LEN       = 8,
  parameter int WRAP_INTERLEAVE = 0,
  parameter int ADDR_W          = 12,
  parameter int MAX_PEND        = 8,
  parameter int INIT_REFS       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_gnt,
  input  logic              self_ref_req,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_cke,
  output logic              init_done,
  output logic              ref_req,
  output logic              ref_busy
);
  localparam int INIT_WAIT    = 100 * CLK_PER_US;
  localparam int REF_INTERVAL = (156 * CLK_PER_US) / 10;
  localparam int TRC          = (75 * CLK_PER_US + 999) / 1000;
  localparam int TRP          = (30 * CLK_PER_US + 999) / 1000;
  localparam int CNT_W        = $clog2(INIT_WAIT + TRC + 3);
  localparam int ICNT_W       = $clog2(INIT_REFS + 1);
  localparam int ALL_BANK_BIT = 10;
  localparam logic [6:0] MODE_BITS =
    mode_bits(CAS_LAT, BURST_LEN, WRAP_INTERLEAVE != 0);
  localparam logic [ADDR_W-1:0] MRS_ADDR = {{(ADDR_W-7){1'b0}}, MODE_BITS};
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << ALL_BANK_BIT;

  typedef enum logic [3:0] {
    ST_PWR, ST_IPRE, ST_IREF, ST_MRS, ST_IDLE,
    ST_BURST, ST_SRPRE, ST_SELF, ST_SREXIT
  } seq_state_t;

  seq_state_t        state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [ICNT_W-1:0] icnt, icnt_n;
  sd_cmd_t           cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              cke_q, cke_n;
  logic              done_q, done_n;
  logic              busy_q, busy_n;
  logic              sr_q;
  logic              tick, owed, dec, clr, tick_en, req_w;

  assign tick_en = done_q && (state != ST_SELF) && (state != ST_SREXIT);
  assign req_w   = (state == ST_IDLE) && (owed || sr_q);

  sdram_ref_tick #(.INTERVAL(REF_INTERVAL)) u_tick (
    .clk (clk), .rst (rst), .en (tick_en), .tick (tick)
  );

  sdram_ref_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
    .clk (clk), .rst (rst), .clr (clr), .inc (tick), .dec (dec), .owed (owed)
  );

  always_comb begin
    state_n = state;
    cnt_n   = (cnt != '0) ? cnt - 1'b1 : cnt;
    icnt_n  = icnt;
    cmd_n   = CMD_NOP;
    addr_n  = '0;
    cke_n   = cke_q;
    done_n  = done_q;
    busy_n  = busy_q;
    dec     = 1'b0;
    clr     = 1'b0;
    case (state)
      ST_PWR: if (cnt == '0) begin
        cmd_n   = CMD_PRE;
        addr_n  = PRE_ADDR;
        cnt_n   = CNT_W'(TRP - 1);
        state_n = ST_IPRE;
      end
      ST_IPRE: if (cnt == '0) begin
        cmd_n   = CMD_REF;
        cnt_n   = CNT_W'(TRC - 1);
        icnt_n  = ICNT_W'(INIT_REFS - 1);
        state_n = ST_IREF;
      end
      ST_IREF: if (cnt == '0) begin
        if (icnt != '0) begin
          cmd_n  = CMD_REF;
          cnt_n  = CNT_W'(TRC - 1);
          icnt_n = icnt - 1'b1;
        end else begin
          cmd_n   = CMD_MRS;
          addr_n  = MRS_ADDR;
          cnt_n   = CNT_W'(1);
          state_n = ST_MRS;
        end
      end
      ST_MRS: if (cnt == '0) begin
        done_n  = 1'b1;
        state_n = ST_IDLE;
      end
      ST_IDLE: if (req_w && ref_gnt) begin
        cmd_n   = CMD_PRE;
        addr_n  = PRE_ADDR;
        cnt_n   = CNT_W'(TRP - 1);
        busy_n  = 1'b1;
        state_n = sr_q ? ST_SRPRE : ST_BURST;
      end
      ST_BURST: if (cnt == '0) begin
        if (owed) begin
          cmd_n = CMD_REF;
          cnt_n = CNT_W'(TRC - 1);
          dec   = 1'b1;
        end else begin
          busy_n  = 1'b0;
          state_n = ST_IDLE;
        end
      end
      ST_SRPRE: if (cnt == '0) begin
        cmd_n   = CMD_REF;
        cke_n   = 1'b0;
        clr     = 1'b1;
        state_n = ST_SELF;
      end
      ST_SELF: if (!sr_q) begin
        cke_n   = 1'b1;
        cnt_n   = CNT_W'(TRC + 1);
        state_n = ST_SREXIT;
      end
      ST_SREXIT: if (cnt == '0) begin
        busy_n  = 1'b0;
        state_n = ST_IDLE;
      end
      default: state_n = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_PWR;
      cnt    <= CNT_W'(INIT_WAIT - 1);
      icnt   <= '0;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      cke_q  <= 1'b1;
      done_q <= 1'b0;
      busy_q <= 1'b0;
      sr_q   <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      icnt   <= icnt_n;
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      cke_q  <= cke_n;
      done_q <= done_n;
      busy_q <= busy_n;
      sr_q   <= self_ref_req;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_cke    = cke_q;
  assign init_done = done_q;
  assign ref_req   = req_w;
  assign ref_busy  = busy_q;
endmodule

// File: rtl/sdram_boot_refresh_chk.sv
module sdram_boot_refresh_chk #(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              sd_cke,
  input logic              init_done,
  input logic              ref_req,
  input logic              ref_busy
);
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  p_pre_all_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> sd_addr[10]);

  p_mrs_word_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (sd_addr == MODE_WORD));

  p_done_delay_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> ##2 init_done);

  p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_req_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> (!ref_busy && init_done));

  p_burst_opens_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_busy) |-> (cmd == 4'b0010));

  p_cke_owned_r8: assert property (@(posedge clk) disable iff (rst)
    !sd_cke |-> ref_busy);

  p_exit_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_cke) |-> (cmd == 4'b0111) ##1 (cmd == 4'b0111));
endmodule

bind sdram_boot_refresh sdram_boot_refresh_chk #(
  .ADDR_W    (ADDR_W),
  .MODE_WORD (MRS_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_addr   (sd_addr),
  .sd_cke    (sd_cke),
  .init_done (init_done),
  .ref_req   (ref_req),
  .ref_busy  (ref_busy)
);

// File: tb/sdram_boot_refresh_bench.sv
`timescale 1ns/1ps
module sdram_boot_refresh_bench;
  localparam int CPU  = 100;
  localparam int INIT = 100 * CPU;
  localparam int INTV = (156 * CPU) / 10;
  localparam int TRC  = (75 * CPU + 999) / 1000;
  localparam int TRP  = (30 * CPU + 999) / 1000;
  localparam logic [11:0] MODE = 12'h02A;  // CL=2, interleave, burst 4
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000;

  logic clk = 0, rst = 1, gnt = 0, sreq = 0;
  logic cs_n, ras_n, cas_n, we_n, cke, done, req, busy;
  logic [11:0] addr;
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always #2 clk = ~clk;

  sdram_boot_refresh #(.CLK_PER_US(CPU), .CAS_LAT(2), .BURST_LEN(4),
                       .WRAP_INTERLEAVE(1)) u_sdram_boot_refresh (
    .clk(clk), .rst(rst), .ref_gnt(gnt), .self_ref_req(sreq),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_addr(addr), .sd_cke(cke), .init_done(done), .ref_req(req),
    .ref_busy(busy));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int t, ph, step, nxt, m_pend, m_tmr;
  bit m_done, m_busy, m_sr, m_cke, m_req;
  logic [3:0]  e_cmd;
  logic [11:0] e_addr;
  string e_tag;

  always @(posedge clk) begin
    if (rst) begin
      t = 0; ph = 0; step = 0; nxt = INIT; m_pend = 0; m_tmr = 0;
      m_done = 0; m_busy = 0; m_sr = 0; m_cke = 1; m_req = 0;
      e_cmd = C_NOP; e_addr = 0; e_tag = "R1";
    end else begin
      bit o_sr, ten, tick, dec, clr;
      int o_pend;
      t++;
      o_sr = m_sr; o_pend = m_pend;
      ten  = m_done && ph != 4 && ph != 5;
      tick = ten && (m_tmr == INTV - 1);
      m_tmr = ten ? (tick ? 0 : m_tmr + 1) : 0;
      e_cmd = C_NOP; e_addr = 0; dec = 0; clr = 0;
      case (ph)
        0: begin
          e_tag = "R2";
          if (t == nxt) begin
            if (step == 0) begin e_cmd = C_PRE; e_addr = 12'h400; nxt += TRP; end
            else if (step <= 8) begin e_cmd = C_REF; nxt += TRC; end
            else if (step == 9) begin e_cmd = C_MRS; e_addr = MODE; nxt += 2; e_tag = "R3"; end
            else begin m_done = 1; ph = 1; e_tag = "R4"; end
            step++;
          end
        end
        1: begin
          e_tag = gnt ? "R10" : "R5";
          if ((o_pend > 0 || o_sr) && gnt) begin
            e_cmd = C_PRE; e_addr = 12'h400; m_busy = 1; nxt = t + TRP;
            ph = o_sr ? 3 : 2; e_tag = o_sr ? "R8" : "R6";
          end
        end
        2: begin
          e_tag = "R6";
          if (t == nxt) begin
            if (o_pend > 0) begin e_cmd = C_REF; dec = 1; nxt = t + TRC; end
            else begin ph = 1; m_busy = 0; end
          end
        end
        3: begin
          e_tag = "R8";
          if (t == nxt) begin e_cmd = C_REF; m_cke = 0; clr = 1; ph = 4; end
        end
        4: begin
          e_tag = "R8";
          if (!o_sr) begin m_cke = 1; nxt = t + TRC + 2; ph = 5; e_tag = "R9"; end
        end
        default: begin
          e_tag = "R9";
          if (t == nxt) begin ph = 1; m_busy = 0; end
        end
      endcase
      if (clr) m_pend = 0;
      else if (tick && !dec) m_pend = (o_pend < 8) ? o_pend + 1 : 8;  // R7 saturation
      else if (!tick && dec) m_pend = o_pend - 1;
      m_sr = sreq;
    end
    m_req = (ph == 1) && (m_pend > 0 || m_sr);
  end

  // Per-cycle comparison and event monitor
  int init_refs = 0, t_mrs = -10, burst_refs = 0, last_burst = -1;
  int t_cke_rise = 0, t_busy_fall = 0;
  bit first_pre = 0, p_done = 0, p_busy = 0, p_cke = 1;

  always @(negedge clk) begin
    if (!rst) begin
      chk(e_tag, "command", cmd, e_cmd);
      chk(e_tag, "address", addr, e_addr);
      chk((ph >= 3) ? "R9" : "R8", "cke", cke, m_cke);
      chk("R4", "init_done", done, m_done);
      chk("R5", "ref_req", req, m_req);
      chk("R6", "ref_busy", busy, m_busy);
      if (cmd == C_PRE && !first_pre) begin
        first_pre = 1;
        chk("R2", "first precharge cycle", t, INIT);
      end
      if (!done && cmd == C_REF) init_refs++;
      if (cmd == C_MRS) begin
        t_mrs = t;
        chk("R3", "mode word", addr, MODE);
        chk("R2", "refreshes before mode set", init_refs, 8);
      end
      if (done && !p_done) chk("R4", "done delay after mode set", t - t_mrs, 2);
      if (busy && !p_busy) burst_refs = 0;
      if (busy && cke && cmd == C_REF) burst_refs++;
      if (!busy && p_busy) begin last_burst = burst_refs; t_busy_fall = t; end
      if (!cke && p_cke) chk("R8", "entry command with cke low", cmd, C_REF);
      if (cke && !p_cke) t_cke_rise = t;
      p_done = done; p_busy = busy; p_cke = cke;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_refs;
    repeat (5) @(negedge clk);
    chk("R1", "reset command", cmd, C_NOP);
    chk("R1", "reset address", addr, 0);
    chk("R1", "reset cke", cke, 1);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset req", req, 0);
    chk("R1", "reset busy", busy, 0);
    rst = 0;
    while (!done) @(negedge clk);

    // R7: long postponement, grant away from any tick
    repeat (10 * INTV) @(negedge clk);
    while (m_tmr != INTV / 2) @(negedge clk);
    gnt = 1;
    while (!busy) @(negedge clk);
    gnt = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R7", "refreshes in saturated burst", last_burst, 8);

    // R6: tick lands on the third refresh edge of a burst
    repeat (4 * INTV) @(negedge clk);
    while (m_tmr != INTV - 20) @(negedge clk);
    exp_refs = m_pend + ((m_pend >= 3) ? 1 : 0);
    gnt = 1;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R6", "refreshes with tick during burst", last_burst, exp_refs);

    // R6/R10: grant held high, single refreshes and idle grants
    repeat (3 * INTV) @(negedge clk);

    // R8/R9: self-refresh entry and exit
    sreq = 1;
    for (int i = 0; i < 200 && cke; i++) @(negedge clk);
    chk("R8", "cke low in self-refresh", cke, 0);
    repeat (300) @(negedge clk);
    chk("R8", "busy held in self-refresh", busy, 1);
    sreq = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R9", "exit quiet cycles", t_busy_fall - t_cke_rise, TRC + 2);

    repeat (2 * INTV) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule